// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous register bus. A two-stage clock divider, with a programmable divide-by-N followed by a selectable power-of-two divide, produces a tick. Each tick steps a 16-bit down-counter. When the counter is found at zero on a tick, it reloads from a reload register. It can also emit a one-cycle interrupt pulse, a reset request held for a fixed number of cycles, or both.

Software keeps the system alive by writing the count register. That write loads the counter at once and restarts the divider phase, so the next expiry is a whole number of ticks away. Clearing the enable bit freezes the count where it stands. Clearing the reset-enable bit drops any reset request that is in progress.

Top module: `wdog_timer`

## Requirements
- R1: After reset the timer is stopped, the control register reads 0x0000, the reload and count registers read 0x8000, and both `irq` and `rst_req` are low.
- R2: The control register is at address 0. Bit 0 is run enable, bit 1 is interrupt enable, bit 2 is reset enable, bits [5:4] are the post-divide select and bits [15:8] are the prescale value. All other bits read back as zero.
- R3: The tick period is (prescale+1) × (16 << select) clock cycles. The first tick comes one full period after the edge that enables the timer or writes the count.
- R4: A write to the count register (address 2) loads the written value into the counter on that edge and restarts the divider phase. This write wins over a tick in the same cycle.
- R5: A tick that finds the counter at zero is an expiry, and the counter reloads from the reload register (address 1). A count of N therefore expires N+1 ticks after it is loaded.
- R6: On an expiry, `irq` is high for exactly one cycle after the expiring edge, and only when interrupt enable is set.
- R7: On an expiry with reset enable set, `rst_req` is high for RST_PULSE cycles (default 4) starting after the expiring edge. With reset enable clear, `rst_req` stays low.
- R8: While run enable is clear, the count holds its value, the divider stays cleared and no expiry occurs. This holds even when the timer is stopped in the middle of a count.
- R9: A read returns data one cycle after the address is presented: address 0 gives control, 1 gives reload, 2 gives the live count and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Expiry interrupt pulse |
| rst_req | output | 1 | System reset request |

## Verification
On every cycle, the assertions check the following:
- the interrupt pulse lasts a single cycle;
- each output only rises while its enable bit was set;
- the reset request ends on time;
- the counter reloads on expiry and takes a written value at once;
- the count stays still while the timer is stopped.

The exact tick period for each prescale and select setting can only be shown by the bench's scenarios. The same holds for the N+1-tick expiry distance, the restart of the divider on a write, the register readback masks and the reset values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 2;
  localparam int PRE_W     = 8;
  localparam int SEL_W     = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

  localparam int B_EN     = 0;
  localparam int B_IRQEN  = 1;
  localparam int B_RSTEN  = 2;
  localparam int B_SEL    = 4;
  localparam int B_PSC    = 8;

  typedef struct packed {
    logic [PRE_W-1:0] psc;
    logic [SEL_W-1:0] sel;
    logic             rst_en;
    logic             irq_en;
    logic             en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_LOAD = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_val,
  output logic [DATA_W-1:0] rdata,
  output wdog_ctrl_t        ctl,
  output logic [DATA_W-1:0] reload,
  output logic              kick,
  output logic [DATA_W-1:0] kick_val
);
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      reload <= RESET_LOAD;
    end else if (we) begin
      if (addr == A_CTRL) begin
        ctl.en     <= wdata[B_EN];
        ctl.irq_en <= wdata[B_IRQEN];
        ctl.rst_en <= wdata[B_RSTEN];
        ctl.sel    <= wdata[B_SEL +: SEL_W];
        ctl.psc    <= wdata[B_PSC +: PRE_W];
      end else if (addr == A_RELOAD) begin
        reload <= wdata;
      end
    end
  end

  always_comb begin
    ctl_word                  = '0;
    ctl_word[B_EN]            = ctl.en;
    ctl_word[B_IRQEN]         = ctl.irq_en;
    ctl_word[B_RSTEN]         = ctl.rst_en;
    ctl_word[B_SEL +: SEL_W]  = ctl.sel;
    ctl_word[B_PSC +: PRE_W]  = ctl.psc;
  end

  always_comb begin
    case (addr)
      A_CTRL:   rd_mux = ctl_word;
      A_RELOAD: rd_mux = reload;
      A_COUNT:  rd_mux = count_val;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign kick     = we && (addr == A_COUNT);
  assign kick_val = wdata;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W         = 8,
  parameter int SEL_W         = 2,
  parameter int POST_BASE_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] psc,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int SEL_SPAN = (1 << SEL_W) - 1;
  localparam int POST_W   = POST_BASE_LOG + SEL_SPAN;

  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic [POST_W-1:0] post_lim;
  logic [SEL_W-1:0]  shamt;
  logic              pre_last;
  logic              post_last;

  assign shamt     = SEL_W'(SEL_SPAN) - sel;
  assign post_lim  = {POST_W{1'b1}} >> shamt;
  assign pre_last  = (pre_cnt == psc);
  assign post_last = (post_cnt == post_lim);
  assign tick      = run && !restart && pre_last && post_last;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (pre_last) begin
      pre_cnt  <= '0;
      post_cnt <= post_last ? '0 : post_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] kick_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= RESET_LOAD;
    else if (kick)   cnt <= kick_val;
    else if (expire) cnt <= reload;
    else if (tick)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdog_event.sv
module wdog_event #(
  parameter int RST_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  output logic irq,
  output logic rst_req
);
  localparam int LEFT_W = $clog2(RST_PULSE + 1);

  logic [LEFT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= expire && irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst || !rst_en)  left <= '0;
    else if (expire)     left <= LEFT_W'(RST_PULSE);
    else if (left != '0) left <= left - 1'b1;
  end

  assign rst_req = (left != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int                RST_PULSE     = 4,
  parameter int                POST_BASE_LOG = 4,
  parameter logic [DATA_W-1:0] RESET_LOAD    = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  wdog_ctrl_t        ctl;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] kick_val;
  logic              kick;
  logic              tick;
  logic              expire;
  logic              ctl_en;
  logic              ctl_irq_en;
  logic              ctl_rst_en;

  assign ctl_en     = ctl.en;
  assign ctl_irq_en = ctl.irq_en;
  assign ctl_rst_en = ctl.rst_en;

  wdog_regs #(.RESET_LOAD(RESET_LOAD)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .count_val(cnt_q), .rdata(bus_rdata), .ctl(ctl), .reload(reload_q),
    .kick(kick), .kick_val(kick_val)
  );

  wdog_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .POST_BASE_LOG(POST_BASE_LOG)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_en), .restart(kick),
    .psc(ctl.psc), .sel(ctl.sel), .tick(tick)
  );

  wdog_counter #(.CNT_W(DATA_W), .RESET_LOAD(RESET_LOAD)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick), .kick_val(kick_val),
    .reload(reload_q), .cnt(cnt_q), .expire(expire)
  );

  wdog_event #(.RST_PULSE(RST_PULSE)) u_evt (
    .clk(clk), .rst(rst), .expire(expire), .irq_en(ctl_irq_en),
    .rst_en(ctl_rst_en), .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int RST_PULSE = 4,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             rst_req,
  input logic             ctl_en,
  input logic             ctl_irq_en,
  input logic             ctl_rst_en,
  input logic             kick,
  input logic [CNT_W-1:0] kick_val,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  logic rst_d;
  int   run;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst || expire) run <= 0;
    else if (rst_req)  run <= run + 1;
  end

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst || rst_d)
    irq |=> !irq);
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(irq) |-> $past(ctl_irq_en));
  assert_rst_gated_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(rst_req) |-> $past(ctl_rst_en));
  assert_rst_length_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
    (run >= RST_PULSE) |-> !rst_req);
  assert_frozen_R8: assert property (@(posedge clk) disable iff (rst || rst_d)
    (!ctl_en && !kick) |=> $stable(cnt_q));
  assert_reload_R5: assert property (@(posedge clk) disable iff (rst || rst_d)
    expire |=> (cnt_q == $past(reload_q)));
  assert_kick_load_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
    kick |=> (cnt_q == $past(kick_val)));
endmodule

bind wdog_timer wdog_timer_chk #(.RST_PULSE(RST_PULSE), .CNT_W(wdog_pkg::DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .rst_req(rst_req), .ctl_en(ctl_en),
  .ctl_irq_en(ctl_irq_en), .ctl_rst_en(ctl_rst_en), .kick(kick),
  .kick_val(kick_val), .expire(expire), .cnt_q(cnt_q), .reload_q(reload_q)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int RST_PULSE  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic        rst_req;

  int errors = 0;
  int checks = 0;

  wdog_timer #(.RST_PULSE(RST_PULSE)) i_wdog_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [15:0] ctl_word(input int psc, input int sel,
                                           input bit rsten, input bit irqen, input bit en);
    return 16'((psc << 8) | (sel << 4) | (int'(rsten) << 2) | (int'(irqen) << 1) | int'(en));
  endfunction

  // waits for irq; returns cycles counted from the last write edge, 0 if none
  task automatic wait_irq(input int max, output int c, output int rst_seen);
    c = 0; rst_seen = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (rst_req) rst_seen++;
      if (irq) begin c = i; return; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int c, rs, p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R9 read addressing
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    rd(2'd0, d); check("R1 ctrl", d, 16'h0000);
    rd(2'd1, d); check("R1 reload", d, 16'h8000);
    rd(2'd2, d); check("R1 count", d, 16'h8000);
    rd(2'd3, d); check("R9 unused addr", d, 0);

    // R2 control readback masks
    wr(2'd0, 16'hFFFE); rd(2'd0, d); check("R2 mask", d, 16'hFF36);
    wr(2'd0, 16'hAB34); rd(2'd0, d); check("R2 fields", d, 16'hAB34);
    wr(2'd1, 16'h8000); rd(2'd1, d); check("R9 reload read", d, 16'h8000);

    // R3/R6/R7/R5 sweep of prescale and select, count 1, interrupt only
    for (int psc = 0; psc < 3; psc++) begin
      for (int sel = 0; sel < 4; sel++) begin
        p = (psc + 1) * (16 << sel);
        wr(2'd0, ctl_word(psc, sel, 0, 1, 0));
        wr(2'd2, 16'd1);
        wr(2'd0, ctl_word(psc, sel, 0, 1, 1));
        wait_irq(3 * p, c, rs);
        check($sformatf("R3 period psc=%0d sel=%0d", psc, sel), c, 2 * p);
        check("R7 no reset when disabled", rs + int'(rst_req), 0);
        rd(2'd2, d);
        check("R5 reload after expiry", d, 16'h8000);
        check("R6 irq one cycle", irq, 0);
      end
    end

    // R5 reload interval: reload 2, count 1, P=16
    wr(2'd0, ctl_word(0, 0, 0, 1, 0));
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd1);
    wr(2'd0, ctl_word(0, 0, 0, 1, 1));
    wait_irq(100, c, rs); check("R5 first expiry", c, 32);
    c = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (irq) begin c = i; break; end
    end
    check("R5 second expiry from reload", c, 48);

    // R7 reset request only, count 0
    wr(2'd0, ctl_word(0, 0, 1, 0, 0));
    wr(2'd2, 16'd0);
    wr(2'd0, ctl_word(0, 0, 1, 0, 1));
    c = 0; rs = 0;
    for (int i = 1; i <= 15; i++) begin
      @(negedge clk);
      rs += int'(rst_req) + int'(irq);
    end
    check("R7 nothing before expiry", rs, 0);
    @(negedge clk);
    check("R7 rst_req at expiry", rst_req, 1);
    check("R6 no irq when disabled", irq, 0);
    c = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rst_req) c++; else break;
    end
    check("R7 pulse length", c, RST_PULSE);

    // R4 kick restarts count and divider phase
    wr(2'd0, ctl_word(0, 0, 0, 1, 0));
    wr(2'd1, 16'h8000);
    wr(2'd2, 16'd2);
    wr(2'd0, ctl_word(0, 0, 0, 1, 1));
    rs = 0;
    for (int i = 0; i < 39; i++) begin @(negedge clk); rs += int'(irq); end
    wr(2'd2, 16'd2);
    check("R4 no early irq", rs, 0);
    wait_irq(100, c, rs); check("R4 expiry after kick", c, 48);

    // R8 freeze: count 5, run two ticks, stop with both enables clear
    wr(2'd0, ctl_word(0, 0, 1, 1, 0));
    wr(2'd2, 16'd5);
    wr(2'd0, ctl_word(0, 0, 1, 1, 1));
    repeat (40) @(negedge clk);
    wr(2'd0, 16'h0000);
    rd(2'd2, d); check("R8 count frozen", d, 3);
    rs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); rs += int'(irq) + int'(rst_req);
    end
    check("R8 no expiry while stopped", rs, 0);
    rd(2'd2, d); check("R8 count still frozen", d, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule